// File: doc/BRIEF.md
# Fourth-Power Carrier Regenerator with Quadrature Divider

The block rebuilds a coherent carrier reference from a real, sampled four-phase (QPSK) signal. It runs in the sample-clock domain, where the carrier completes one cycle every 16 samples. There is no tracking loop. Each valid sample is raised to the fourth power, which removes the four-phase modulation and leaves a strong tone at four times the carrier. A fixed second-order resonator tuned to a quarter of the sample rate selects that tone and rejects the DC term that the fourth power creates. A sign slicer turns the filtered tone into a two-level signal, and each rising transition of that signal gives a one-cycle step pulse.

The step pulse advances a two-register twisted-ring counter. It is clock-enabled and is not used as a clock. Its two true outputs and two inverted outputs form four carrier-rate reference phases, each 90 degrees from the next. A 2-bit select input picks one of them as the registered reference output. Software or a later stage uses this select to resolve the 90-degree ambiguity that fourth-power recovery always leaves.

Top module: `carrier_regen`

## Requirements
- R1: While reset is high and on the cycle after it, `tick_o` is 0, `ref_o` is 0 and `phase_o` is 4'b1100, because both ring registers are cleared.
- R2: A valid sample x (signed, IN_W=12 bits) becomes s = floor(x*x / 2^7) and then q = floor(s*s / 2^15), an unsigned 16-bit value. Invalid samples do not enter the pipeline.
- R3: On each valid value q the resonator computes y = q[n] - q[n-2] - (y[n-2] - (y[n-2] >>> 4)) in signed arithmetic. Its delay state moves only on valid values and starts at zero after reset.
- R4: `tick_o` is high for exactly one cycle, 4 cycles after the valid sample whose y is greater than 0 when the y of the previous valid sample was not greater than 0. After reset the previous y counts as not positive.
- R5: Samples presented with `samp_valid_i` low, whatever their value, produce no tick and do not change `phase_o` or the filter state.
- R6: With ring state {B,A} = {`phase_o[1]`,`phase_o[0]`}, each tick moves the state to {A,~B}, so from reset it runs 00, 01, 11, 10, 00. The new state is visible on the cycle after the tick. Without a tick the state holds.
- R7: `phase_o[2]` = ~A and `phase_o[3]` = ~B. Each `phase_o[k]` takes the value that `phase_o[k-1]` had before the most recent tick, and each phase is high for two of every four ticks.
- R8: `ref_o` equals `phase_o[phase_sel_i]` as sampled on the previous clock edge.
- R9: A constant input produces no ticks once the resonator transient has decayed, about 900 samples at most for full-scale input.
- R10: An unmodulated carrier at fs/16, sampled away from the zero crossings of the fourth-power tone, gives ticks exactly 4 samples apart once settled. Each reference phase therefore has a period of 16 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_i | input | IN_W | Signed input sample |
| samp_valid_i | input | 1 | Marks `samp_i` as a valid sample |
| phase_sel_i | input | 2 | Index of the phase driven onto `ref_o` |
| tick_o | output | 1 | One-cycle pulse on each rising edge of the sliced tone |
| phase_o | output | 4 | Four quadrature reference phases {~B,~A,B,A} |
| ref_o | output | 1 | Registered selected reference phase |

## Verification
A sample drives `tick_o` four cycles after the edge that captures it. The ring state moves one cycle after a tick, and `ref_o` follows one cycle after that. The bench keeps a ring of expected ticks indexed by sample, reads the entry from four cycles back, and derives the expected ring state from the expected tick of the previous cycle. It derives the expected `ref_o` from the previous cycle's expected phases and select. All outputs are sampled on the falling edge, so each comparison falls on the cycle in which its result is due, including across gaps in `samp_valid_i`.

// File: rtl/carrier_regen_pkg.sv
package carrier_regen_pkg;

  // Ring state packed as {B, A}
  typedef logic [1:0] ring_state_t;

  // Advance of the twisted ring: A takes ~B, B takes A
  function automatic ring_state_t ring_advance(ring_state_t s);
    return {s[0], ~s[1]};
  endfunction

  // Four quadrature phases: {~B, ~A, B, A}
  function automatic logic [3:0] ring_phases(ring_state_t s);
    return {~s[1], ~s[0], s[1], s[0]};
  endfunction

endpackage

// File: rtl/quartic_stage.sv
module quartic_stage #(
  parameter int IN_W = 12,
  parameter int P_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic signed [IN_W-1:0] x_i,
  input  logic                   vld_i,
  output logic [P_W-1:0]         q_o,
  output logic                   vld_o
);
  localparam int SQ_W     = 2 * IN_W;
  localparam int QF_W     = 2 * P_W;
  localparam int SQ_SHIFT = 2 * IN_W - 1 - P_W;
  localparam int Q_SHIFT  = P_W - 1;

  logic signed [SQ_W-1:0] sq_full;
  logic [QF_W-1:0]        q_full;
  logic [P_W-1:0]         sq_q;
  logic                   v1_q;

  assign sq_full = x_i * x_i;
  assign q_full  = sq_q * sq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_q  <= '0;
      v1_q  <= 1'b0;
      q_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      v1_q  <= vld_i;
      vld_o <= v1_q;
      if (vld_i) sq_q <= sq_full[SQ_SHIFT +: P_W];
      if (v1_q)  q_o  <= q_full[Q_SHIFT +: P_W];
    end
  end
endmodule

// File: rtl/fs4_resonator.sv
module fs4_resonator #(
  parameter int P_W     = 16,
  parameter int GUARD   = 8,
  parameter int R_SHIFT = 4,
  localparam int Y_W    = P_W + GUARD
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [P_W-1:0]        q_i,
  input  logic                  vld_i,
  output logic signed [Y_W-1:0] y_o,
  output logic                  vld_o
);
  logic [P_W-1:0]        xd1_q, xd2_q;
  logic signed [Y_W-1:0] yd2_q;
  logic signed [Y_W-1:0] q_ext, xd2_ext, y_damp, y_new;

  assign q_ext   = $signed({{(Y_W-P_W){1'b0}}, q_i});
  assign xd2_ext = $signed({{(Y_W-P_W){1'b0}}, xd2_q});
  assign y_damp  = yd2_q - (yd2_q >>> R_SHIFT);
  assign y_new   = q_ext - xd2_ext - y_damp;

  always_ff @(posedge clk) begin
    if (rst) begin
      xd1_q <= '0;
      xd2_q <= '0;
      y_o   <= '0;
      yd2_q <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        xd1_q <= q_i;
        xd2_q <= xd1_q;
        y_o   <= y_new;
        yd2_q <= y_o;
      end
    end
  end
endmodule

// File: rtl/edge_slicer.sv
module edge_slicer #(
  parameter int Y_W = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic signed [Y_W-1:0] y_i,
  input  logic                  vld_i,
  output logic                  step_o
);
  logic pos_now, pos_q;

  assign pos_now = !y_i[Y_W-1] && (y_i != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= 1'b0;
      step_o <= 1'b0;
    end else begin
      step_o <= vld_i && pos_now && !pos_q;
      if (vld_i) pos_q <= pos_now;
    end
  end
endmodule

// File: rtl/twisted_ring_div.sv
module twisted_ring_div
  import carrier_regen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step_i,
  output logic [3:0] phase_o
);
  ring_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst)         st_q <= '0;
    else if (step_i) st_q <= ring_advance(st_q);
  end

  assign phase_o = ring_phases(st_q);
endmodule

// File: rtl/carrier_regen.sv
module carrier_regen #(
  parameter int IN_W    = 12,
  parameter int P_W     = 16,
  parameter int GUARD   = 8,
  parameter int R_SHIFT = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic signed [IN_W-1:0] samp_i,
  input  logic                   samp_valid_i,
  input  logic [1:0]             phase_sel_i,
  output logic                   tick_o,
  output logic [3:0]             phase_o,
  output logic                   ref_o
);
  localparam int Y_W = P_W + GUARD;

  logic [P_W-1:0]        q_w;
  logic                  q_vld;
  logic signed [Y_W-1:0] y_w;
  logic                  y_vld;
  logic                  step_w;

  quartic_stage #(.IN_W(IN_W), .P_W(P_W)) u_quartic (
    .clk(clk), .rst(rst), .x_i(samp_i), .vld_i(samp_valid_i),
    .q_o(q_w), .vld_o(q_vld)
  );

  fs4_resonator #(.P_W(P_W), .GUARD(GUARD), .R_SHIFT(R_SHIFT)) u_reson (
    .clk(clk), .rst(rst), .q_i(q_w), .vld_i(q_vld),
    .y_o(y_w), .vld_o(y_vld)
  );

  edge_slicer #(.Y_W(Y_W)) u_slicer (
    .clk(clk), .rst(rst), .y_i(y_w), .vld_i(y_vld), .step_o(step_w)
  );

  twisted_ring_div u_ring (
    .clk(clk), .rst(rst), .step_i(step_w), .phase_o(phase_o)
  );

  assign tick_o = step_w;

  always_ff @(posedge clk) begin
    if (rst) ref_o <= 1'b0;
    else     ref_o <= phase_o[phase_sel_i];
  end
endmodule

// File: rtl/carrier_regen_chk.sv
module carrier_regen_chk (
  input logic       clk,
  input logic       rst,
  input logic       samp_valid_i,
  input logic [1:0] phase_sel_i,
  input logic       tick_o,
  input logic [3:0] phase_o,
  input logic       ref_o
);
  AST_RING_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (phase_o[1:0] == {$past(phase_o[0]), ~$past(phase_o[1])})); // R6
  AST_RING_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_o |=> $stable(phase_o)); // R6
  AST_PHASE_LAG: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (phase_o[3:1] == $past(phase_o[2:0]))); // R7
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R4
  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !$past(samp_valid_i, 4) |-> !tick_o); // R5
  AST_REF_SELECT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ref_o == $past(phase_o[phase_sel_i]))); // R8
endmodule

bind carrier_regen carrier_regen_chk u_chk (.*);

// File: tb/tb_carrier_regen.sv
module tb_carrier_regen;
  localparam int IN_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [IN_W-1:0] samp = '0;
  logic vld = 1'b0;
  logic [1:0] sel = 2'd0;
  logic tick;
  logic [3:0] phase;
  logic refo;

  carrier_regen #(.IN_W(IN_W)) dut (
    .clk(clk), .rst(rst), .samp_i(samp), .samp_valid_i(vld),
    .phase_sel_i(sel), .tick_o(tick), .phase_o(phase), .ref_o(refo)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // reference model state
  longint m_xd1 = 0, m_xd2 = 0, m_yd1 = 0, m_yd2 = 0;
  bit m_pos = 0;
  bit ring_exp [8];
  int it = 0;
  logic [1:0] st_m = 2'b00;
  bit last_tick = 0;
  logic [3:0] ph_prev = 4'b1100;
  logic [1:0] sel_prev = 2'd0;
  string tick_tag = "R4 tick (R2 R3 chain)";
  bit track = 0;
  int last_tick_it = -1;
  int tick_count = 0;

  function automatic logic [3:0] phases_of(logic [1:0] s);
    return {~s[1], ~s[0], s[1], s[0]};
  endfunction

  function automatic logic signed [IN_W-1:0] tone(int n, int quad);
    real a;
    a = 2.0 * 3.14159265358979 * n / 16.0 + 3.14159265358979 / 16.0
        + 3.14159265358979 / 4.0 + quad * 3.14159265358979 / 2.0;
    return IN_W'($rtoi(1800.0 * $cos(a)));
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, it);
    end
  endtask

  task automatic cycle(input logic signed [IN_W-1:0] x, input bit v, input logic [1:0] s);
    bit exp_tick, t;
    logic [3:0] exp_ph;
    logic exp_ref;
    longint xl, sq, q, y;
    @(negedge clk);
    exp_tick = ring_exp[(it + 4) & 7];
    if (last_tick) st_m = {st_m[0], ~st_m[1]};
    exp_ph  = phases_of(st_m);
    exp_ref = ph_prev[sel_prev];
    check(tick_tag, int'(tick), int'(exp_tick));
    check("R6 R7 phase", int'(phase), int'(exp_ph));
    check("R8 ref", int'(refo), int'(exp_ref));
    if (tick) tick_count++;
    if (track && tick) begin
      if (last_tick_it >= 0) check("R10 tick spacing", it - last_tick_it, 4);
      last_tick_it = it;
    end
    last_tick = exp_tick;
    ph_prev   = exp_ph;
    sel_prev  = s;
    t = 0;
    if (v) begin
      xl = longint'(x);
      sq = (xl * xl) >> 7;
      q  = (sq * sq) >> 15;
      y  = q - m_xd2 - (m_yd2 - (m_yd2 >>> 4));
      m_xd2 = m_xd1; m_xd1 = q;
      m_yd2 = m_yd1; m_yd1 = y;
      t = (y > 0) && !m_pos;
      m_pos = (y > 0);
    end
    ring_exp[it & 7] = t;
    it++;
    samp = x; vld = v; sel = s;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int base, nv, win_ticks;
    repeat (3) @(negedge clk);
    check("R1 reset phase", int'(phase), 12);
    check("R1 reset ref", int'(refo), 0);
    check("R1 reset tick", int'(tick), 0);
    rst = 1'b0;

    // QPSK symbols, all four quadrants, select swept
    for (int n = 0; n < 640; n++)
      cycle(tone(n, ((n / 32) * 3) % 4), 1'b1, 2'((n / 37) % 4));

    // unmodulated tone, spacing tracked once settled
    last_tick_it = -1;
    base = tick_count;
    for (int n = 0; n < 400; n++) begin
      if (n == 200) begin track = 1; base = tick_count; end
      cycle(tone(n, 2), 1'b1, 2'(n / 100));
    end
    track = 0;
    check("R10 tick count in window", (tick_count - base) >= 45 ? 1 : 0, 1);

    // sparse valid, then a long invalid burst with extreme values
    tick_tag = "R5 tick with invalid gaps";
    nv = 0;
    for (int n = 0; n < 200; n++) begin
      if (n % 3 != 2) begin cycle(tone(nv, 1), 1'b1, 2'd3); nv++; end
      else cycle(12'sh7FF, 1'b0, 2'd3);
    end
    for (int n = 0; n < 24; n++)
      cycle((n % 2) ? 12'sh800 : 12'sh7FF, 1'b0, 2'(n % 4));
    tick_tag = "R4 tick (R2 R3 chain)";

    // DC input: transient must die out
    for (int n = 0; n < 1200; n++) begin
      if (n == 900) win_ticks = tick_count;
      cycle(12'sd1800, 1'b1, 2'(n % 4));
    end
    check("R9 ticks under DC", tick_count - win_ticks, 0);

    // tone again after DC
    for (int n = 0; n < 300; n++)
      cycle(tone(n, 0), 1'b1, 2'((n / 23) % 4));

    summary();
    $finish;
  end
endmodule